// File: doc/BRIEF.md
# Early-Terminating Sequential Shift-Add Multiplier

This block multiplies two signed 32-bit mantissas, one conditional add per clock, and gives a signed 64-bit product. A one-cycle `start` pulse loads the operands. Each negative operand is first turned into its positive magnitude. The multiplicand register then shifts left and the multiplier register shifts right until no set bits remain. While this runs, the multiplicand is added into a 64-bit accumulator on every cycle in which the low bit of the multiplier register is set. The loop stops as soon as the multiplier register is zero, so the latency depends on the data. A small operand finishes in a few cycles, and the worst case is 32 cycles. The product sign is restored at the output from the XOR of the two input signs.

The wrapper also takes two 8-bit signed exponents. It captures their sum on the same `start` pulse and flags the exponent as invalid when that addition gives an unsigned carry-out or a signed overflow. A 56-bit packed word puts the exponent sum above the low 48 bits of the signed product. No rounding, normalisation or recoding is done.

Top module: `smul_fp_mult`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `start`, `done` is 0, `product` is 0, `packed_result` is 0 and `exp_ok` is 1.
- R2: For non-negative operands, `product` equals the exact 64-bit product of `a_mant` and `b_mant` once `done` is 1.
- R3: When exactly one operand is negative, `product` is the two's-complement negation of the magnitude product. When both operands are negative, `product` is positive. This includes operands equal to -2^31.
- R4: Call the rising edge that samples `start` high the load edge. Let N be the bit length of |`b_mant`|, meaning the position of its highest set bit plus one. `done` is low after the first N-1 rising edges that follow the load edge and is high after the N-th. N is at most 32.
- R5: If |`b_mant`| is zero, `done` is already high right after the load edge and `product` is 0.
- R6: Once `done` is high and `start` stays low, `done`, `product`, `exp_sum`, `exp_ok` and `packed_result` hold their values, whatever the operand inputs do.
- R7: A `start` pulse during a running operation abandons it. The new operands are loaded and the result and latency follow R2 to R5 for the new operands.
- R8: `exp_sum` becomes the 8-bit wrapped sum of `a_exp` and `b_exp` as sampled on the load edge.
- R9: `exp_ok` is 0 exactly when that 8-bit addition gives an unsigned carry-out or a signed (two's-complement) overflow. Otherwise it is 1.
- R10: `packed_result[55:48]` equals `exp_sum` and `packed_result[47:0]` equals `product[47:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads operands and clears the accumulator |
| a_mant | input | 32 | Signed multiplicand mantissa |
| b_mant | input | 32 | Signed multiplier mantissa |
| a_exp | input | 8 | Signed exponent of operand A |
| b_exp | input | 8 | Signed exponent of operand B |
| product | output | 64 | Signed product, valid while `done` is high |
| done | output | 1 | High when the shifted multiplier register is all zeros |
| exp_sum | output | 8 | Captured exponent sum |
| exp_ok | output | 1 | Low when the exponent sum is not valid |
| packed_result | output | 56 | Exponent sum above the low 48 product bits |

## Verification
Assertions check these properties on every cycle:
- A finished result stays stable until the next `start`.
- No operation stays busy longer than 32 cycles after its load.
- A non-zero product carries the sign recorded at load.
- A valid exponent sum is never smaller than the captured A exponent.

Only the directed scenarios can show other properties:
- The exact product values.
- The exact cycle on which `done` rises for each operand bit length, including a zero multiplier.
- That a restart in mid-run drops `done` at once.
- The carry and overflow cases of the exponent adder, including the packing of the 56-bit word.

// File: rtl/smul_pkg.sv
package smul_pkg;

   // Form of the conditional two's-complement negation
   typedef enum logic {
      NEG_MUX = 1'b0,   // select between x and 0-x
      NEG_XOR = 1'b1    // invert under mask, then add the mask bit
   } neg_style_e;

endpackage

// File: rtl/smul_cond_negate.sv
module smul_cond_negate
   import smul_pkg::*;
#(
   parameter int         W     = 32,
   parameter neg_style_e STYLE = NEG_XOR
) (
   input  logic [W-1:0] din,
   input  logic         neg,
   output logic [W-1:0] dout
);

   generate
      if (W < 2) begin : g_bad_w
         $error("smul_cond_negate: W must be at least 2");
      end

      if (STYLE == NEG_XOR) begin : g_xor
         logic [W-1:0] mask;
         logic [W-1:0] inc;
         always_comb begin
            mask = {W{neg}};
            inc  = {{(W-1){1'b0}}, neg};
            dout = (din ^ mask) + inc;
         end
      end else begin : g_mux
         always_comb begin
            dout = neg ? (~din + {{(W-1){1'b0}}, 1'b1}) : din;
         end
      end
   endgenerate

endmodule

// File: rtl/smul_shift_add_core.sv
module smul_shift_add_core #(
   parameter int MANT_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MANT_W-1:0]   mag_a,
   input  logic [MANT_W-1:0]   mag_b,
   input  logic                neg_in,
   output logic [2*MANT_W-1:0] acc_out,
   output logic                neg_out,
   output logic                done
);

   localparam int PROD_W = 2 * MANT_W;
   localparam int CYC_W  = $clog2(MANT_W + 1) + 1;

   logic [PROD_W-1:0] mcand_q;
   logic [MANT_W-1:0] mplier_q;
   logic [PROD_W-1:0] acc_q;
   logic              loaded_q;
   logic              neg_q;
   logic              mplier_zero;

   assign mplier_zero = (mplier_q == '0);
   assign done        = loaded_q && mplier_zero;
   assign acc_out     = acc_q;
   assign neg_out     = neg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
         loaded_q <= 1'b0;
         neg_q    <= 1'b0;
      end else if (start) begin
         mcand_q  <= {{(PROD_W-MANT_W){1'b0}}, mag_a};
         mplier_q <= mag_b;
         acc_q    <= '0;
         loaded_q <= 1'b1;
         neg_q    <= neg_in;
      end else if (loaded_q && !mplier_zero) begin
         if (mplier_q[0]) begin
            acc_q <= acc_q + mcand_q;
         end
         mcand_q  <= {mcand_q[PROD_W-2:0], 1'b0};
         mplier_q <= {1'b0, mplier_q[MANT_W-1:1]};
      end
   end

   // Cycle count since the load, kept for the latency bound check
   logic [CYC_W-1:0] cyc_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (start) begin
         cyc_q <= '0;
      end else if (loaded_q && !mplier_zero && (cyc_q != '1)) begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   // R4
   latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_q && !done && !start) |-> (cyc_q < CYC_W'(MANT_W)));

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(acc_q) && $stable(neg_q)));

endmodule

// File: rtl/smul_exp_adder.sv
module smul_exp_adder #(
   parameter int EXP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [EXP_W-1:0] a_exp,
   input  logic [EXP_W-1:0] b_exp,
   output logic [EXP_W-1:0] exp_sum,
   output logic             exp_ok
);

   logic [EXP_W:0]   wide_sum;
   logic             carry;
   logic             ovf;
   logic [EXP_W-1:0] sum_q;
   logic             ok_q;

   always_comb begin
      wide_sum = {1'b0, a_exp} + {1'b0, b_exp};
      carry    = wide_sum[EXP_W];
      ovf      = (a_exp[EXP_W-1] == b_exp[EXP_W-1]) &&
                 (wide_sum[EXP_W-1] != a_exp[EXP_W-1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         ok_q  <= 1'b1;
      end else if (start) begin
         sum_q <= wide_sum[EXP_W-1:0];
         ok_q  <= !(carry || ovf);
      end
   end

   assign exp_sum = sum_q;
   assign exp_ok  = ok_q;

   // R9
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!exp_ok || (exp_sum >= $past(a_exp))));

endmodule

// File: rtl/smul_fp_mult.sv
module smul_fp_mult
   import smul_pkg::*;
#(
   parameter int         MANT_W     = 32,
   parameter int         EXP_W      = 8,
   parameter int         PACK_LOW_W = 48,
   parameter neg_style_e NEG_STYLE  = NEG_XOR
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [MANT_W-1:0]           a_mant,
   input  logic [MANT_W-1:0]           b_mant,
   input  logic [EXP_W-1:0]            a_exp,
   input  logic [EXP_W-1:0]            b_exp,
   output logic [2*MANT_W-1:0]         product,
   output logic                        done,
   output logic [EXP_W-1:0]            exp_sum,
   output logic                        exp_ok,
   output logic [EXP_W+PACK_LOW_W-1:0] packed_result
);

   localparam int PROD_W = 2 * MANT_W;

   generate
      if (MANT_W < 2) begin : g_bad_mant
         $error("smul_fp_mult: MANT_W must be at least 2");
      end
      if (EXP_W < 2) begin : g_bad_exp
         $error("smul_fp_mult: EXP_W must be at least 2");
      end
      if (PACK_LOW_W < 1 || PACK_LOW_W > PROD_W) begin : g_bad_pack
         $error("smul_fp_mult: PACK_LOW_W must lie in 1..2*MANT_W");
      end
   endgenerate

   logic [MANT_W-1:0] mag_a;
   logic [MANT_W-1:0] mag_b;
   logic [PROD_W-1:0] acc_mag;
   logic              neg_q;
   logic              core_done;

   smul_cond_negate #(.W(MANT_W), .STYLE(NEG_STYLE)) i_abs_a (
      .din  (a_mant),
      .neg  (a_mant[MANT_W-1]),
      .dout (mag_a)
   );

   smul_cond_negate #(.W(MANT_W), .STYLE(NEG_STYLE)) i_abs_b (
      .din  (b_mant),
      .neg  (b_mant[MANT_W-1]),
      .dout (mag_b)
   );

   smul_shift_add_core #(.MANT_W(MANT_W)) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mag_a   (mag_a),
      .mag_b   (mag_b),
      .neg_in  (a_mant[MANT_W-1] ^ b_mant[MANT_W-1]),
      .acc_out (acc_mag),
      .neg_out (neg_q),
      .done    (core_done)
   );

   smul_cond_negate #(.W(PROD_W), .STYLE(NEG_STYLE)) i_sign_fix (
      .din  (acc_mag),
      .neg  (neg_q),
      .dout (product)
   );

   smul_exp_adder #(.EXP_W(EXP_W)) i_exp (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .a_exp   (a_exp),
      .b_exp   (b_exp),
      .exp_sum (exp_sum),
      .exp_ok  (exp_ok)
   );

   assign done          = core_done;
   assign packed_result = {exp_sum, product[PACK_LOW_W-1:0]};

   // R3
   sign_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (product != '0)) |-> (product[PROD_W-1] == neg_q));

   // R6
   packed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> ($stable(packed_result) && $stable(exp_ok)));

endmodule

// File: tb/test_smul_fp_mult.sv
`timescale 1ns/100ps
module test_smul_fp_mult;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] a_mant = '0;
   logic [31:0] b_mant = '0;
   logic [7:0]  a_exp = '0;
   logic [7:0]  b_exp = '0;
   logic [63:0] product;
   logic        done;
   logic [7:0]  exp_sum;
   logic        exp_ok;
   logic [55:0] packed_result;

   int tests_run = 0;
   int tests_failed = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   smul_fp_mult i_smul_fp_mult (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .a_mant        (a_mant),
      .b_mant        (b_mant),
      .a_exp         (a_exp),
      .b_exp         (b_exp),
      .product       (product),
      .done          (done),
      .exp_sum       (exp_sum),
      .exp_ok        (exp_ok),
      .packed_result (packed_result)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         tests_failed = tests_failed + 1;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      tests_run++;
      if (!ok) begin
         tests_failed++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int bit_len(input logic [31:0] v);
      longint m;
      int n;
      m = $signed(v);
      if (m < 0) m = -m;
      n = 0;
      while (m != 0) begin
         n++;
         m = m >>> 1;
      end
      return n;
   endfunction

   // Runs one operation and checks product, latency, exponent and packing
   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] ea, input logic [7:0] eb,
                         input string tag);
      longint   exp_p;
      logic [8:0] s9;
      bit       ovf;
      bit       exp_valid;
      int       lat;
      bit       early;
      exp_p = longint'($signed(a)) * longint'($signed(b));
      s9    = {1'b0, ea} + {1'b0, eb};
      ovf   = (ea[7] == eb[7]) && (s9[7] != ea[7]);
      exp_valid = !(s9[8] || ovf);
      lat   = bit_len(b);
      @(negedge clk);
      a_mant = a; b_mant = b; a_exp = ea; b_exp = eb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      early = 1'b0;
      for (int n = 0; n < lat; n++) begin
         if (done) early = 1'b1;
         @(negedge clk);
      end
      // R4: done low before N edges, high after the N-th
      chk(!early && done, {tag, " R4 latency"}, {63'd0, done}, 64'd1);
      // R2 / R3 product value
      chk(product == exp_p, {tag, " R2 R3 product"}, product, exp_p);
      // R8 exponent sum
      chk(exp_sum == s9[7:0], {tag, " R8 exp_sum"}, {56'd0, exp_sum}, {56'd0, s9[7:0]});
      // R9 exponent validity
      chk(exp_ok == exp_valid, {tag, " R9 exp_ok"}, {63'd0, exp_ok}, {63'd0, exp_valid});
      // R10 packing
      chk(packed_result == {s9[7:0], exp_p[47:0]}, {tag, " R10 packed"},
          {8'd0, packed_result}, {8'd0, s9[7:0], exp_p[47:0]});
   endtask

   task automatic t_reset();
      @(negedge clk);
      // R1
      chk(done == 1'b0 && product == '0 && packed_result == '0 && exp_ok == 1'b1,
          "R1 reset state", {done, exp_ok, 6'd0, packed_result}, {1'b0, 1'b1, 62'd0});
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && product == '0, "R1 idle after reset",
          {63'd0, done}, 64'd0);
   endtask

   task automatic t_positive();
      run_op(32'd7, 32'd9, 8'd10, 8'd20, "pos small");
      run_op(32'd123456, 32'd65535, 8'd1, 8'd2, "pos mid");
      run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 8'd0, 8'd0, "pos max");
   endtask

   task automatic t_signs();
      run_op(-32'sd5, 32'd3, 8'd3, 8'd4, "R3 neg*pos");
      run_op(32'd5, -32'sd3, 8'd3, 8'd4, "R3 pos*neg");
      run_op(-32'sd5, -32'sd3, 8'd3, 8'd4, "R3 neg*neg");
      run_op(32'h8000_0000, 32'h8000_0000, 8'd0, 8'd0, "R3 min*min");
      run_op(32'h8000_0000, 32'd1, 8'd0, 8'd0, "R3 min*one");
   endtask

   task automatic t_zero_mult();
      run_op(32'd12345, 32'd0, 8'd5, 8'd6, "R5 zero multiplier");
      run_op(32'd0, 32'd5, 8'd5, 8'd6, "R5 zero multiplicand");
   endtask

   task automatic t_hold();
      logic [63:0] p0;
      logic [55:0] k0;
      run_op(-32'sd1000, 32'd777, 8'd9, 8'd9, "R6 setup");
      p0 = product;
      k0 = packed_result;
      a_mant = 32'hDEAD_BEEF; b_mant = 32'h1234_5678; a_exp = 8'h7F; b_exp = 8'h7F;
      repeat (10) @(negedge clk);
      // R6
      chk(done && product == p0 && packed_result == k0, "R6 hold",
          product, p0);
   endtask

   task automatic t_restart();
      @(negedge clk);
      a_mant = 32'd3; b_mant = 32'hFFFF_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      @(negedge clk);
      a_mant = 32'd3; b_mant = 32'd4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R7: done dropped on reload (|b|=4 needs 3 edges)
      chk(done == 1'b0, "R7 restart clears done", {63'd0, done}, 64'd0);
      repeat (3) @(negedge clk);
      chk(done && product == 64'd12, "R7 restart result", product, 64'd12);
   endtask

   task automatic t_exp();
      run_op(32'd2, 32'd2, 8'd100, 8'd100, "R9 signed overflow");
      run_op(32'd2, 32'd2, 8'hFF, 8'hFF, "R9 carry out");
      run_op(32'd2, 32'd2, 8'h80, 8'h80, "R9 carry and overflow");
      run_op(32'd2, 32'd2, 8'h40, 8'h3F, "R9 max valid");
   endtask

   initial begin
      t_reset();
      t_positive();
      t_signs();
      t_zero_mult();
      t_hold();
      t_restart();
      t_exp();
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule